// File: doc/BRIEF.md
# Interval and free-running timer channel

One timer channel on a simple register bus. Software loads a compare value and picks one of two modes through a control bit, then fires a start trigger. In interval mode the counter climbs from zero to the compare value and reloads, so loading N−1 gives one interrupt pulse every N clocks. In free-running mode the counter climbs through its whole range and wraps, and a one-cycle interrupt pulse marks each clock in which it equals the compare value. That pulse serves either as a timestamp source or as a single deadline event.

Start and stop are separate write-only triggers. A readable enable flag shows whether the channel is running. A stop is applied one clock after its write, and the enable flag keeps reading 1 until then. Software can therefore poll the flag to learn when the stop is complete. Compare and control are locked while the channel runs.

The bus uses a single-cycle write strobe and returns read data combinationally from the address. Registers at byte offsets: compare 0x00 (read/write), counter 0x04 (read-only), enable status 0x10 (read-only, bit 0), start trigger 0x14 (write-only, bit 0), stop trigger 0x18 (write-only, bit 0), control 0x20 (read/write, bit 1 = mode: 0 interval, 1 free-running).

Top module: `tmr_channel`

## Requirements
- R1: After reset the enable flag, the counter, the compare register, the control register and `irq` all read 0.
- R2: Compare (0x00) reads back what was written. Control (0x20) keeps only bit 1, and its other bits read 0. The trigger offsets 0x14 and 0x18 and every unmapped offset read 0.
- R3: A write to 0x14 with bit 0 set, made while the channel is stopped, sets enable-status bit 0 (0x10) from the next clock and clears the counter to 0 on the same edge. A start write with bit 0 clear has no effect.
- R4: A write to 0x18 with bit 0 set, made while the channel is running, leaves the enable flag at 1 and the counter still counting for one more clock. From the second edge after the write, the flag reads 0 and the counter holds its value.
- R5: A start write made in the clock where a stop is pending is discarded, and the channel ends stopped.
- R6: In interval mode (control bit 1 = 0) with compare N−1, the counter runs 0..N−1 and reloads to 0. `irq` is high for one clock every N clocks, in the clock after the counter held N−1.
- R7: In free-running mode (control bit 1 = 1), the counter increments by one every clock and continues past the compare value. It wraps from all ones to 0. `irq` is high for exactly the one clock after each clock in which the counter equals compare.
- R8: In free-running mode with compare 0, `irq` pulses in the first clock after the start edge, and the counter keeps counting.
- R9: Writes to compare or control while the enable flag reads 1 are ignored.
- R10: `irq` is high only in a clock that follows a clock in which the channel was running.
- R11: A start write while the channel is running neither clears nor disturbs the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-clock interrupt pulse on each match or expiry |

## Verification
The bound assertions check the cycle-level rules on every clock: the one-clock stop latency with the enable flag still high, the compare lock while running, the increment and reload of the counter, the hold while stopped, and the irq that follows every match and only ever follows a running clock. Several behaviours need whole sequences and are shown only by the bench scenarios: the exact interval period, the free-running wrap from all ones, the immediate pulse for a zero compare, a start arriving while a stop is pending, and the register readback values seen at the bus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register byte offsets; software addresses these, so they are fixed.
  localparam int unsigned OFS_CMP   = 32'h00;
  localparam int unsigned OFS_CNT   = 32'h04;
  localparam int unsigned OFS_STAT  = 32'h10;
  localparam int unsigned OFS_START = 32'h14;
  localparam int unsigned OFS_STOP  = 32'h18;
  localparam int unsigned OFS_CTRL  = 32'h20;

  // Field positions.
  localparam int unsigned TRIG_BIT = 0;  // start/stop trigger and status flag
  localparam int unsigned MODE_BIT = 1;  // control: mode select

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_FREE     = 1'b1
  } tmr_mode_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          run_st,
  input  logic [DW-1:0] cnt_q,
  output logic [DW-1:0] cmp_q,
  output tmr_mode_e     mode_q,
  output logic          start_req,
  output logic          stop_req,
  output logic [DW-1:0] bus_rdata
);

  function automatic logic addr_is(input logic [AW-1:0] a, input int unsigned ofs);
    return a == AW'(ofs);
  endfunction

  logic hit_cmp, hit_cnt, hit_stat, hit_start, hit_stop, hit_ctrl;
  logic cfg_open;

  assign hit_cmp   = addr_is(bus_addr, OFS_CMP);
  assign hit_cnt   = addr_is(bus_addr, OFS_CNT);
  assign hit_stat  = addr_is(bus_addr, OFS_STAT);
  assign hit_start = addr_is(bus_addr, OFS_START);
  assign hit_stop  = addr_is(bus_addr, OFS_STOP);
  assign hit_ctrl  = addr_is(bus_addr, OFS_CTRL);

  // Configuration is writable only while the channel is stopped.
  assign cfg_open = bus_wr && !run_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= MODE_INTERVAL;
    end else begin
      if (cfg_open && hit_cmp)  cmp_q  <= bus_wdata;
      if (cfg_open && hit_ctrl) mode_q <= tmr_mode_e'(bus_wdata[MODE_BIT]);
    end
  end

  assign start_req = bus_wr && hit_start && bus_wdata[TRIG_BIT];
  assign stop_req  = bus_wr && hit_stop  && bus_wdata[TRIG_BIT];

  always_comb begin
    bus_rdata = '0;
    if (hit_cmp)       bus_rdata = cmp_q;
    else if (hit_cnt)  bus_rdata = cnt_q;
    else if (hit_stat) bus_rdata[TRIG_BIT] = run_st;
    else if (hit_ctrl) bus_rdata[MODE_BIT] = mode_q;
  end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  output logic run_st,
  output logic stop_pend,
  output logic start_go
);

  logic stop_go;

  // A start counts only from a fully stopped channel with no stop alongside.
  assign start_go = start_req && !run_st && !stop_req;
  // A stop is latched once; repeated stops during the pending clock are absorbed.
  assign stop_go  = stop_req && run_st && !stop_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_st    <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      stop_pend <= stop_go;
      if (stop_pend)     run_st <= 1'b0;
      else if (start_go) run_st <= 1'b1;
    end
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_st,
  input  logic          start_go,
  input  tmr_mode_e     mode_q,
  input  logic [DW-1:0] cmp_q,
  output logic [DW-1:0] cnt_q,
  output logic          match_evt,
  output logic          irq
);

  function automatic logic hits(input logic [DW-1:0] c, input logic [DW-1:0] k);
    return c == k;
  endfunction

  // Next count while running: interval mode reloads after the compare value.
  function automatic logic [DW-1:0] advance(input logic [DW-1:0] c,
                                            input logic [DW-1:0] k,
                                            input tmr_mode_e m);
    if (m == MODE_INTERVAL && hits(c, k)) return '0;
    return c + 1'b1;
  endfunction

  assign match_evt = run_st && hits(cnt_q, cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= match_evt;
      if (start_go)    cnt_q <= '0;
      else if (run_st) cnt_q <= advance(cnt_q, cmp_q, mode_q);
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  logic [DW-1:0] cmp_q;
  logic [DW-1:0] cnt_q;
  tmr_mode_e     mode_q;
  logic          start_req, stop_req;
  logic          run_st, stop_pend, start_go;
  logic          match_evt;

  tmr_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .run_st    (run_st),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .mode_q    (mode_q),
    .start_req (start_req),
    .stop_req  (stop_req),
    .bus_rdata (bus_rdata)
  );

  tmr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .run_st    (run_st),
    .stop_pend (stop_pend),
    .start_go  (start_go)
  );

  tmr_count #(.DW(DW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_st    (run_st),
    .start_go  (start_go),
    .mode_q    (mode_q),
    .cmp_q     (cmp_q),
    .cnt_q     (cnt_q),
    .match_evt (match_evt),
    .irq       (irq)
  );

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_st,
  input logic          stop_pend,
  input logic          start_go,
  input logic          match_evt,
  input tmr_mode_e     mode_q,
  input logic [DW-1:0] cmp_q,
  input logic [DW-1:0] cnt_q,
  input logic          irq
);

  AST_STOP_STILL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pend |-> run_st); // R4

  AST_STOP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pend |=> !run_st); // R4

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_st && !start_go) |=> $stable(cnt_q)); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (run_st && cnt_q == '0)); // R3

  AST_CMP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run_st |=> ($stable(cmp_q) && $stable(mode_q))); // R9

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && !(mode_q == MODE_INTERVAL && match_evt)) |=> cnt_q == DW'($past(cnt_q) + 1'b1)); // R7

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && mode_q == MODE_INTERVAL && match_evt) |=> cnt_q == '0); // R6

  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> irq); // R7

  AST_IRQ_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run_st)); // R10

endmodule

bind tmr_channel tmr_channel_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_st    (run_st),
  .stop_pend (stop_pend),
  .start_go  (start_go),
  .match_evt (match_evt),
  .mode_q    (mode_q),
  .cmp_q     (cmp_q),
  .cnt_q     (cnt_q),
  .irq       (irq)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;

  localparam int DW = 12;
  localparam int AW = 6;
  localparam int WRAP = 1 << DW;

  localparam logic [AW-1:0] A_CMP   = 6'h00;
  localparam logic [AW-1:0] A_CNT   = 6'h04;
  localparam logic [AW-1:0] A_STAT  = 6'h10;
  localparam logic [AW-1:0] A_START = 6'h14;
  localparam logic [AW-1:0] A_STOP  = 6'h18;
  localparam logic [AW-1:0] A_CTRL  = 6'h20;
  localparam logic [AW-1:0] A_HOLE  = 6'h08;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_channel #(.DW(DW), .AW(AW)) u_tmr_channel (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [AW-1:0] a, input int d);
    bus_addr  = a;
    bus_wdata = DW'(d);
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic stop_and_settle();
    wr(A_STOP, 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_CNT, v);  check("R1 counter", v, 0);
    rd(A_CMP, v);  check("R1 compare", v, 0);
    rd(A_CTRL, v); check("R1 control", v, 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_regmap();
    int v;
    wr(A_CMP, 'hA5C);
    rd(A_CMP, v);   check("R2 compare readback", v, 'hA5C);
    wr(A_CTRL, 'hFF);
    rd(A_CTRL, v);  check("R2 control only bit1", v, 2);
    rd(A_START, v); check("R2 start reads 0", v, 0);
    rd(A_STOP, v);  check("R2 stop reads 0", v, 0);
    rd(A_HOLE, v);  check("R2 unmapped reads 0", v, 0);
    wr(A_CTRL, 0);
    wr(A_START, 2);
    rd(A_STAT, v);  check("R3 start bit0 clear ignored", v, 0);
  endtask

  task automatic t_interval();
    int v;
    wr(A_CMP, 4);
    wr(A_CTRL, 0);
    wr(A_START, 1);
    rd(A_STAT, v); check("R3 status after start", v, 1);
    rd(A_CNT, v);  check("R3 counter cleared", v, 0);
    for (int i = 1; i <= 15; i++) begin
      @(negedge clk);
      rd(A_CNT, v);
      check("R6 interval count", v, i % 5);
      check("R6 interval irq", int'(irq), (i % 5 == 0) ? 1 : 0);
    end
    stop_and_settle();
  endtask

  task automatic t_stop_timing();
    int v, c1;
    wr(A_CMP, 100);
    wr(A_CTRL, 2);
    wr(A_START, 1);
    repeat (3) @(negedge clk);
    wr(A_STOP, 1);
    rd(A_STAT, v); check("R4 status still 1 after stop write", v, 1);
    rd(A_CNT, c1);
    @(negedge clk);
    rd(A_STAT, v); check("R4 status 0 after stop", v, 0);
    rd(A_CNT, v);  check("R4 last count step", v, c1 + 1);
    repeat (3) @(negedge clk);
    rd(A_CNT, v);  check("R4 counter held", v, c1 + 1);
  endtask

  task automatic t_start_vs_stop();
    int v, c1;
    wr(A_START, 1);
    repeat (2) @(negedge clk);
    wr(A_STOP, 1);
    wr(A_START, 1);
    rd(A_STAT, v); check("R5 start during pending stop", v, 0);
    rd(A_CNT, c1);
    @(negedge clk);
    rd(A_STAT, v); check("R5 stays stopped", v, 0);
    rd(A_CNT, v);  check("R5 counter held", v, c1);
  endtask

  task automatic t_free_wrap();
    int v;
    int bad = 0;
    int pulses = 0;
    wr(A_CMP, 7);
    wr(A_CTRL, 2);
    wr(A_START, 1);
    for (int i = 1; i <= WRAP + 12; i++) begin
      @(negedge clk);
      rd(A_CNT, v);
      if (v != i % WRAP) bad++;
      if (int'(irq) != (((i - 1) % WRAP == 7) ? 1 : 0)) bad++;
      if (irq) pulses++;
      if (i == WRAP - 1) check("R7 reaches all ones", v, WRAP - 1);
      if (i == WRAP)     check("R7 wraps to zero", v, 0);
    end
    check("R7 count and irq every cycle", bad, 0);
    check("R7 one pulse per match", pulses, 2);
    stop_and_settle();
  endtask

  task automatic t_free_zero();
    int v;
    wr(A_CMP, 0);
    wr(A_CTRL, 2);
    wr(A_START, 1);
    check("R8 no irq at start edge", int'(irq), 0);
    @(negedge clk);
    check("R8 irq on first clock", int'(irq), 1);
    @(negedge clk);
    check("R8 irq single", int'(irq), 0);
    rd(A_CNT, v); check("R8 keeps counting", v, 2);
    stop_and_settle();
  endtask

  task automatic t_lock_and_restart();
    int v, c1;
    wr(A_CMP, 50);
    wr(A_CTRL, 2);
    wr(A_START, 1);
    wr(A_CMP, 9);
    wr(A_CTRL, 0);
    rd(A_CMP, v);  check("R9 compare locked", v, 50);
    rd(A_CTRL, v); check("R9 control locked", v, 2);
    rd(A_CNT, c1);
    wr(A_START, 1);
    rd(A_CNT, v);  check("R11 restart ignored", v, c1 + 1);
    stop_and_settle();
    repeat (3) @(negedge clk);
    check("R10 no irq while stopped", int'(irq), 0);
    wr(A_CMP, 9);
    rd(A_CMP, v);  check("R9 compare writable when stopped", v, 9);
  endtask

  initial begin
    #3000000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_interval();
    t_stop_timing();
    t_start_vs_stop();
    t_free_zero();
    t_lock_and_restart();
    t_free_wrap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule